// File: doc/BRIEF.md
# Lag-Sweep Autocorrelation Engine

This block computes the one-sided autocorrelation of a finished block of signed audio samples. A sample block of `BLOCK_LEN` entries sits in an external memory with two read ports. After a start pulse the engine steps through every lag from zero up to `BLOCK_LEN-1`. For each lag it adds up the products of sample pairs that lie that many positions apart and stay inside the block. As the lag grows, each sum has fewer terms: lag `i` has `BLOCK_LEN-i` of them.

The engine does one multiply-accumulate per clock. Lags form the outer loop and the sample index the inner loop. Each finished sum goes to a result memory at the address equal to its lag. A one-cycle done pulse follows the last write.

The samples must be scaled beforehand so that the stored results are meaningful. The internal accumulator is sized so that it never wraps, and the stored value saturates to the result width. At the default size of 330 samples, one block takes 54,618 cycles. That is about 1.1 ms at 50 MHz, far below a 30 ms block period.

Top module: `acorr_engine`

## Requirements
- R1: After a synchronous reset, `busy`, `done` and `wr_en` are all low.
- R2: For every lag i in 0..BLOCK_LEN-1 the engine writes the sum over j from 0 to BLOCK_LEN-1-i of x[j]*x[j+i], where x[k] is the signed sample at memory address k. Read data is expected one cycle after the address. Both read addresses stay below BLOCK_LEN.
- R3: The accumulator holds 2*SAMPLE_W+ceil(log2(BLOCK_LEN)) signed bits and never wraps. A written result is the exact sum clamped to the signed RESULT_W range, from -2^(RESULT_W-1) to 2^(RESULT_W-1)-1.
- R4: Results are written in ascending lag order, with wr_addr equal to the lag. Each lag is written exactly once per run.
- R5: The engine performs one multiply-accumulate per clock. `done` is high exactly BLOCK_LEN*(BLOCK_LEN+1)/2+3 cycles after the cycle in which an accepted `start` is sampled high.
- R6: A `start` seen while `busy` is high is ignored. It changes neither the results nor the timing of the current run, and it starts no second run.
- R7: `done` is high for exactly one cycle: the cycle right after the write for lag BLOCK_LEN-1. `busy` is low while `done` is high.
- R8: The accumulator restarts from zero at the first term of every lag, so no sum carries terms from a previous lag.
- R9: A `start` presented in the same cycle as `done` is accepted and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; accepted only while not busy |
| busy | output | 1 | High from the cycle after acceptance until done |
| done | output | 1 | One-cycle completion pulse |
| rd_addr_a | output | ADDR_W | Sample memory address for the index term x[j] |
| rd_addr_b | output | ADDR_W | Sample memory address for the lagged term x[j+i] |
| rd_data_a | input | SAMPLE_W | Signed sample for rd_addr_a, one cycle later |
| rd_data_b | input | SAMPLE_W | Signed sample for rd_addr_b, one cycle later |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | ADDR_W | Result address (the lag) |
| wr_data | output | RESULT_W | Signed, saturated autocorrelation value |

## Verification
The bench targets several corner cases, each with a distinct failure it would expose:
- **Lag-zero and impulse blocks.** These expose a read pipeline that pairs the wrong cycle's data, which would spread energy into nonzero lags.
- **Full-scale blocks.** All samples at +32767, at -32768, or alternating in sign. These force positive and negative saturation. A design that truncates instead of clamping would store wrapped values with the wrong sign.
- **The last, one-term lag and the cycle count.** These catch an off-by-one on the shrinking inner loop, which would drop or add a product and shift `done`.
- **Start pulses at run time.** Pulses mid-run, on the final write cycle, and on the `done` cycle itself show whether a restart corrupts a run in flight or a legal back-to-back start is lost.

// File: rtl/acorr_pkg.sv
package acorr_pkg;

    // Sequencer phase
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Control tag that travels alongside each product
    typedef struct packed {
        logic vld;        // a product is in flight
        logic first;      // first term of its lag
        logic last;       // last term of its lag
        logic final_lag;  // last term of the last lag
    } mac_tag_t;

    // Number of products in one block (sum of BLOCK_LEN..1)
    function automatic int unsigned tri_count(input int unsigned n);
        return (n * (n + 1)) / 2;
    endfunction

    // Accumulator width that cannot wrap for n products of two sw-bit values
    function automatic int unsigned acc_width(input int unsigned sw, input int unsigned n);
        return 2 * sw + ((n > 1) ? $clog2(n) : 1);
    endfunction

    function automatic int unsigned addr_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/acorr_seq.sv
module acorr_seq
    import acorr_pkg::*;
#(
    parameter int unsigned BLOCK_LEN = 330,
    parameter int unsigned ADDR_W    = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    output logic [ADDR_W-1:0] rd_addr_a,
    output logic [ADDR_W-1:0] rd_addr_b,
    output mac_tag_t          tag_o,
    output logic [ADDR_W-1:0] lag_o
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(BLOCK_LEN - 1);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] lag_q;
    logic [ADDR_W-1:0] idx_q;
    logic              lag_end;
    logic              block_end;

    assign lag_end   = (idx_q == (LAST - lag_q));
    assign block_end = lag_end && (lag_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            lag_q   <= '0;
            idx_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (launch) begin
                        state_q <= SEQ_RUN;
                        lag_q   <= '0;
                        idx_q   <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (lag_end) begin
                        idx_q <= '0;
                        if (lag_q == LAST) begin
                            state_q <= SEQ_IDLE;
                            lag_q   <= '0;
                        end else begin
                            lag_q <= lag_q + 1'b1;
                        end
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign rd_addr_a = idx_q;
    assign rd_addr_b = idx_q + lag_q;
    assign lag_o     = lag_q;

    always_comb begin
        tag_o           = '0;
        tag_o.vld       = (state_q == SEQ_RUN);
        tag_o.first     = (state_q == SEQ_RUN) && (idx_q == '0);
        tag_o.last      = (state_q == SEQ_RUN) && lag_end;
        tag_o.final_lag = (state_q == SEQ_RUN) && block_end;
    end

    // R2
    addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_RUN) |-> (rd_addr_b <= LAST && rd_addr_a <= LAST));

    // R4
    lag_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_RUN && lag_end && lag_q != LAST)
        |=> (lag_q == $past(lag_q) + 1'b1 && idx_q == '0 && state_q == SEQ_RUN));

endmodule

// File: rtl/acorr_mac.sv
module acorr_mac
    import acorr_pkg::*;
#(
    parameter int unsigned BLOCK_LEN = 330,
    parameter int unsigned SAMPLE_W  = 16,
    parameter int unsigned RESULT_W  = 32,
    parameter int unsigned ADDR_W    = 9
) (
    input  logic                       clk,
    input  logic                       rst,
    input  mac_tag_t                   tag_i,
    input  logic [ADDR_W-1:0]          lag_i,
    input  logic signed [SAMPLE_W-1:0] smp_a,
    input  logic signed [SAMPLE_W-1:0] smp_b,
    output logic                       wr_en,
    output logic [ADDR_W-1:0]          wr_addr,
    output logic signed [RESULT_W-1:0] wr_data,
    output logic                       final_wr
);

    localparam int unsigned ACC_W  = acc_width(SAMPLE_W, BLOCK_LEN);
    localparam int unsigned PROD_W = 2 * SAMPLE_W;

    // Tag delayed by the memory's one-cycle read latency
    mac_tag_t          s1_tag;
    logic [ADDR_W-1:0] s1_lag;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_tag <= '0;
            s1_lag <= '0;
        end else begin
            s1_tag <= tag_i;
            s1_lag <= lag_i;
        end
    end

    logic signed [PROD_W-1:0]   prod;
    logic signed [ACC_W-1:0]    prod_ext;
    logic signed [ACC_W-1:0]    acc_q;
    logic signed [ACC_W-1:0]    acc_base;
    logic signed [ACC_W-1:0]    acc_next;
    logic signed [RESULT_W-1:0] res_val;

    assign prod     = smp_a * smp_b;
    assign prod_ext = ACC_W'(prod);
    assign acc_base = s1_tag.first ? '0 : acc_q;
    assign acc_next = acc_base + prod_ext;

    generate
        if (RESULT_W >= ACC_W) begin : g_wide
            assign res_val = RESULT_W'(acc_next);
        end else begin : g_clamp
            localparam logic signed [ACC_W-1:0] RES_MAX =
                {{(ACC_W - RESULT_W + 1){1'b0}}, {(RESULT_W - 1){1'b1}}};
            localparam logic signed [ACC_W-1:0] RES_MIN =
                {{(ACC_W - RESULT_W + 1){1'b1}}, {(RESULT_W - 1){1'b0}}};
            always_comb begin
                if (acc_next > RES_MAX)
                    res_val = RES_MAX[RESULT_W-1:0];
                else if (acc_next < RES_MIN)
                    res_val = RES_MIN[RESULT_W-1:0];
                else
                    res_val = acc_next[RESULT_W-1:0];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            final_wr <= 1'b0;
        end else begin
            if (s1_tag.vld)
                acc_q <= acc_next;
            wr_en    <= s1_tag.vld && s1_tag.last;
            final_wr <= s1_tag.vld && s1_tag.final_lag;
            if (s1_tag.vld && s1_tag.last) begin
                wr_addr <= s1_lag;
                wr_data <= res_val;
            end
        end
    end

    // R8
    acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (s1_tag.vld && s1_tag.first) |=> (acc_q == $past(prod_ext)));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (s1_tag.vld && !s1_tag.first && !acc_q[ACC_W-1] && !prod_ext[ACC_W-1])
        |-> !acc_next[ACC_W-1]);

endmodule

// File: rtl/acorr_engine.sv
module acorr_engine
    import acorr_pkg::*;
#(
    parameter  int unsigned BLOCK_LEN = 330,
    parameter  int unsigned SAMPLE_W  = 16,
    parameter  int unsigned RESULT_W  = 32,
    localparam int unsigned ADDR_W    = addr_width(BLOCK_LEN)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    output logic                       busy,
    output logic                       done,
    output logic [ADDR_W-1:0]          rd_addr_a,
    output logic [ADDR_W-1:0]          rd_addr_b,
    input  logic signed [SAMPLE_W-1:0] rd_data_a,
    input  logic signed [SAMPLE_W-1:0] rd_data_b,
    output logic                       wr_en,
    output logic [ADDR_W-1:0]          wr_addr,
    output logic signed [RESULT_W-1:0] wr_data
);

    localparam int unsigned RUN_CYC = tri_count(BLOCK_LEN) + 3;
    localparam int unsigned CNT_W   = $clog2(RUN_CYC + 1);

    logic              busy_q;
    logic              done_q;
    logic              launch;
    logic              final_wr;
    mac_tag_t          tag;
    logic [ADDR_W-1:0] lag;

    assign launch = start && !busy_q;

    acorr_seq #(
        .BLOCK_LEN (BLOCK_LEN),
        .ADDR_W    (ADDR_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .rd_addr_a (rd_addr_a),
        .rd_addr_b (rd_addr_b),
        .tag_o     (tag),
        .lag_o     (lag)
    );

    acorr_mac #(
        .BLOCK_LEN (BLOCK_LEN),
        .SAMPLE_W  (SAMPLE_W),
        .RESULT_W  (RESULT_W),
        .ADDR_W    (ADDR_W)
    ) u_mac (
        .clk      (clk),
        .rst      (rst),
        .tag_i    (tag),
        .lag_i    (lag),
        .smp_a    (rd_data_a),
        .smp_b    (rd_data_b),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .final_wr (final_wr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= final_wr;
            if (launch)
                busy_q <= 1'b1;
            else if (final_wr)
                busy_q <= 1'b0;
        end
    end

    assign busy = busy_q;
    assign done = done_q;

    // Cycle counter since the accepted start, used by the latency check
    logic [CNT_W-1:0] run_cnt;
    always_ff @(posedge clk) begin
        if (rst)
            run_cnt <= '0;
        else if (launch)
            run_cnt <= CNT_W'(1);
        else if (busy_q)
            run_cnt <= run_cnt + 1'b1;
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6
    start_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !final_wr) |=> (busy && !done));

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_cnt == CNT_W'(RUN_CYC)));

endmodule

// File: tb/acorr_engine_test.sv
module acorr_engine_test;

    localparam int N  = 20;
    localparam int SW = 16;
    localparam int RW = 32;
    localparam int AW = $clog2(N);
    localparam int M  = N * (N + 1) / 2;
    localparam longint RMAX = (longint'(1) <<< (RW - 1)) - 1;
    localparam longint RMIN = -(longint'(1) <<< (RW - 1));

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start = 1'b0;
    logic                 busy, done, wr_en;
    logic [AW-1:0]        rd_addr_a, rd_addr_b, wr_addr;
    logic signed [SW-1:0] rd_data_a, rd_data_b;
    logic signed [RW-1:0] wr_data;

    always #2 clk = ~clk;

    acorr_engine #(.BLOCK_LEN(N), .SAMPLE_W(SW), .RESULT_W(RW)) uut (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // Sample memory model with one-cycle read latency
    logic signed [SW-1:0] mem [N];
    always_ff @(posedge clk) begin
        rd_data_a <= mem[rd_addr_a];
        rd_data_b <= mem[rd_addr_b];
    end

    int     checks = 0;
    int     errors = 0;
    longint got  [N];
    int     seen [N];
    int     next_lag  = 0;
    int     order_err = 0;
    int     writes    = 0;
    bit     finished  = 1'b0;

    // Result memory capture, away from the active edge
    always @(negedge clk) begin
        if (!rst && wr_en) begin
            writes = writes + 1;
            if (int'(wr_addr) != next_lag) order_err = order_err + 1;
            if (int'(wr_addr) < N) begin
                got[wr_addr]  = longint'(wr_data);
                seen[wr_addr] = seen[wr_addr] + 1;
            end
            next_lag = next_lag + 1;
        end
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint expect_lag(input int lag);
        longint s = 0;
        for (int j = 0; j + lag < N; j++)
            s += longint'(mem[j]) * longint'(mem[j + lag]);
        if (s > RMAX) s = RMAX;
        if (s < RMIN) s = RMIN;
        return s;
    endfunction

    // Runs one block. pre: start was already raised in the previous done cycle.
    // poke: pulse start while busy. chain: raise start in the done cycle.
    task automatic run_block(input string name, input string req, input bit poke,
                             input bit pre, input bit chain);
        int cyc;
        for (int k = 0; k < N; k++) begin got[k] = 0; seen[k] = 0; end
        next_lag = 0; order_err = 0; writes = 0;
        if (!pre) begin
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        cyc = 1;
        while (!done && cyc < M + 100) begin
            start = poke && (cyc == N || cyc == M + 1 || cyc == M + 2);
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        // R5: one product per clock, fixed latency
        check("R5", {name, " start-to-done cycles"}, cyc, M + 3);
        // R7: busy low during done, done follows last write
        check("R7", {name, " busy during done"}, busy, 0);
        check("R7", {name, " writes before done"}, writes, N);
        if (chain) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7", {name, " done width"}, done, 0);
        if (chain) check("R9", {name, " start on done accepted"}, busy, 1);
        check("R4", {name, " write order errors"}, order_err, 0);
        for (int i = 0; i < N; i++) begin
            check("R4", $sformatf("%s lag %0d write count", name, i), seen[i], 1);
            check(req, $sformatf("%s lag %0d", name, i), got[i], expect_lag(i));
        end
    endtask

    function automatic logic [15:0] lfsr_step(input logic [15:0] v);
        return v[0] ? ((v >> 1) ^ 16'hB400) : (v >> 1);
    endfunction

    initial begin
        logic [15:0] seed;
        for (int k = 0; k < N; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "busy in reset", busy, 0);
        check("R1", "done in reset", done, 0);
        check("R1", "wr_en in reset", wr_en, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "busy after reset", busy, 0);
        check("R1", "done after reset", done, 0);
        check("R1", "wr_en after reset", wr_en, 0);

        // R2: all-zero block
        run_block("zeros", "R2", 1'b0, 1'b0, 1'b0);

        // R2: single impulse -> only lag 0 nonzero
        for (int k = 0; k < N; k++) mem[k] = (k == 7) ? 16'sd1000 : 16'sd0;
        run_block("impulse", "R2", 1'b0, 1'b0, 1'b0);

        // R8: constant block, each lag must restart its sum
        for (int k = 0; k < N; k++) mem[k] = 16'sd3;
        run_block("constant", "R8", 1'b0, 1'b0, 1'b0);

        // R2: signed ramp
        for (int k = 0; k < N; k++) mem[k] = SW'((k - 10) * 100);
        run_block("ramp", "R2", 1'b0, 1'b0, 1'b0);

        // R2/R6: pseudo-random block with start pulses while busy
        seed = 16'hACE1;
        for (int k = 0; k < N; k++) begin
            seed = lfsr_step(seed);
            mem[k] = $signed(seed) >>> 3;
        end
        run_block("random-poke", "R6", 1'b1, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        // R6: the ignored pulses must not have begun another run
        check("R6", "busy after ignored starts", busy, 0);
        check("R6", "writes after ignored starts", writes, N);

        // R3: positive saturation
        for (int k = 0; k < N; k++) mem[k] = 16'sd32767;
        run_block("full-pos", "R3", 1'b0, 1'b0, 1'b0);

        // R3: negative saturation on odd lags
        for (int k = 0; k < N; k++) mem[k] = (k % 2 == 0) ? 16'sd32767 : -16'sd32767;
        run_block("alternate", "R3", 1'b0, 1'b0, 1'b0);

        // R3: most negative sample, product 2^30 each
        for (int k = 0; k < N; k++) mem[k] = 16'h8000;
        run_block("full-neg", "R3", 1'b0, 1'b0, 1'b1);

        // R9: run started in the done cycle of the previous run
        run_block("chained", "R3", 1'b0, 1'b1, 1'b0);

        // R2: second random block
        seed = 16'h1D2B;
        for (int k = 0; k < N; k++) begin
            seed = lfsr_step(seed);
            mem[k] = $signed(seed);
        end
        run_block("random-wide", "R2", 1'b0, 1'b0, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R5 watchdog expired: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule